// File: doc/BRIEF.md
# Stereo serial converter port

The block turns parallel 16-bit left/right sample pairs into the three-wire stream an external audio converter expects. It has a frame clock that runs at the sample rate, a bit clock and one data line. Each frame clock period holds 32 bit slots: the left word comes first and the right word follows. The frame clock is high or low during the left word, depending on the selected format.

In master mode the block makes both clocks itself from the system clock through a programmable divider. In slave mode it follows a bit clock and frame clock from outside: it synchronises them and aligns its slot counter to the edge of the frame clock that starts the left word. Three settings can change at run time: the framing format (MSB first, LSB first, or I2S-style), the clock role, and the sample coding (two's complement or offset binary). The port works only while it is enabled and the external-converter option is selected.

A sample pair is captured on `valid_i`. It is copied into the shift path at the start of each frame, so a pair that is not renewed is sent again.

Top module: `stereo_ser_port`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, bclk_o, fclk_o and sdata_o are all 0.
- R2: With fmt_i = 2'b00, the left-word slots are the 16 bit slots that start where fclk_o rises, and fclk_o is high for all of them. The next 16 slots, with fclk_o low, carry the right word. Each word is sent MSB first, and its first bit is in the first slot of its half.
- R3: With fmt_i = 2'b01, the framing is the same as in R2 but each word is sent LSB first.
- R4: fmt_i = 2'b10 produces the same stream as fmt_i = 2'b00.
- R5: With fmt_i = 2'b11, fclk_o is low during the left half and high during the right half. Each word is sent MSB first and starts one bit slot after the frame-clock edge of its half. The first slot after fclk_o falls carries the LSB of the previous right word.
- R6: With offset_bin_i = 1, bit 15 of every sent word is the inverse of the captured sample bit. With offset_bin_i = 0, words are sent unchanged.
- R7: A pair on left_i/right_i is captured in a cycle where valid_i = 1 and is sent from the next frame start on. If no new pair arrives, the last captured pair is sent again in every frame.
- R8: In master mode (master_i = 1), bclk_o has a period of 2*(clk_div_i+1) system clocks. sdata_o and fclk_o change only in the cycle where bclk_o falls.
- R9: In slave mode (master_i = 0), the port follows bclk_i and fclk_i. It treats the fclk_i edge that starts the left half (the rising edge, or the falling edge for fmt_i = 2'b11) as slot 0, and it updates sdata_o after each bclk_i falling edge. bclk_o and fclk_o stay 0.
- R10: Unless en_i = 1 and ext_dac_i = 1, bclk_o, fclk_o and sdata_o are 0 from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| ext_dac_i | input | 1 | External converter option selected |
| master_i | input | 1 | 1: drive the clocks, 0: follow external clocks |
| fmt_i | input | 2 | Framing: 00/10 MSB first, 01 LSB first, 11 I2S-style |
| offset_bin_i | input | 1 | 1: send offset binary (sample MSB inverted) |
| clk_div_i | input | DIV_W | Master bit-clock half period in system clocks, minus one |
| valid_i | input | 1 | Capture left_i/right_i |
| left_i | input | SAMPLE_W | Left sample |
| right_i | input | SAMPLE_W | Right sample |
| bclk_i | input | 1 | External bit clock (slave mode) |
| fclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Bit clock (master mode) |
| fclk_o | output | 1 | Frame clock (master mode) |
| sdata_o | output | 1 | Serial data |

## Verification
The assertions check on every cycle that, in master mode, data and frame-clock changes line up with bit-clock falling edges and that the frame clock moves only at slot 0 or slot 16. They also check that the divided bit clock never toggles on two cycles in a row when the divider is above zero, and that the outputs go quiet once the port is not running. Only the bench scenarios can show that bit order, the one-slot I2S delay, the MSB inversion, pair repetition and slave frame alignment give the right words: it captures whole frames at the bit-clock rising edges and rebuilds the left and right words.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    FMT_MSB = 2'b00,
    FMT_LSB = 2'b01,
    FMT_ALT = 2'b10,
    FMT_I2S = 2'b11
  } ser_fmt_e;
endpackage

// File: rtl/ser_bclk_gen.sv
module ser_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             bclk_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign fall_o = run_i & wrap & bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // half period is at least two cycles when the divider is non-zero
  assert_half_period_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $stable(div_i) && div_i != '0 && $changed(bclk_q))
      |=> (!run_i || $stable(bclk_q)));
endmodule

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int STAGES = 2,
  parameter int N      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic         fall0_o
);
  logic fall_d_q;

  for (genvar g = 0; g < N; g++) begin : g_chain
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_d_q <= 1'b0;
    else         fall_d_q <= sync_o[0];
  end

  assign fall0_o = fall_d_q & ~sync_o[0];
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import ser_pkg::*;
#(
  parameter int SAMPLE_W = 16  // power of two
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                step_i,
  input  logic                master_i,
  input  logic                ext_fclk_i,
  input  logic [1:0]          fmt_i,
  input  logic                offset_bin_i,
  input  logic [SAMPLE_W-1:0] hold_l_i,
  input  logic [SAMPLE_W-1:0] hold_r_i,
  output logic                sdata_o,
  output logic                fclk_o
);
  localparam int SLOTS  = 2 * SAMPLE_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(SAMPLE_W);
  localparam logic [IDX_W-1:0]    K_TOP = IDX_W'(SAMPLE_W - 1);
  localparam logic [SAMPLE_W-1:0] MSB_M = {1'b1, {(SAMPLE_W-1){1'b0}}};

  ser_fmt_e            fmt;
  logic                i2s, lsb_first, lft_now, frame_start;
  logic [SLOT_W-1:0]   slot_q, slot_nxt, src;
  logic [SAMPLE_W-1:0] cur_l_q, cur_r_q, new_l, new_r, word_l, word;
  logic [IDX_W-1:0]    k;
  logic                lft_prev_q, sdata_q, fclk_q, bit_nxt, fclk_nxt;

  always_comb begin
    fmt         = ser_fmt_e'(fmt_i);
    i2s         = (fmt == FMT_I2S);
    lsb_first   = (fmt == FMT_LSB);
    lft_now     = ext_fclk_i ^ i2s;
    // slave realigns on the left-half edge, master free-runs
    slot_nxt    = (!master_i && lft_now && !lft_prev_q) ? '0 : slot_q + 1'b1;
    frame_start = (slot_nxt == '0);
    new_l       = hold_l_i ^ (offset_bin_i ? MSB_M : '0);
    new_r       = hold_r_i ^ (offset_bin_i ? MSB_M : '0);
    word_l      = frame_start ? new_l : cur_l_q;
    // I2S slot 0 still carries the old right LSB
    src         = i2s ? slot_nxt - 1'b1 : slot_nxt;
    word        = src[SLOT_W-1] ? cur_r_q : word_l;
    k           = src[IDX_W-1:0];
    bit_nxt     = lsb_first ? word[k] : word[K_TOP - k];
    fclk_nxt    = master_i & (~slot_nxt[SLOT_W-1] ^ i2s);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q     <= '1;
      lft_prev_q <= 1'b1;
      sdata_q    <= 1'b0;
      fclk_q     <= 1'b0;
      cur_l_q    <= '0;
      cur_r_q    <= '0;
    end else if (!run_i) begin
      slot_q     <= '1;
      lft_prev_q <= 1'b1;
      sdata_q    <= 1'b0;
      fclk_q     <= 1'b0;
    end else if (step_i) begin
      slot_q     <= slot_nxt;
      lft_prev_q <= lft_now;
      sdata_q    <= bit_nxt;
      fclk_q     <= fclk_nxt;
      if (frame_start) begin
        cur_l_q <= new_l;
        cur_r_q <= new_r;
      end
    end
  end

  assign sdata_o = sdata_q;
  assign fclk_o  = fclk_q;

  // frame clock moves only at the half boundaries
  assert_fclk_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && master_i && $past(master_i) && $stable(fmt_i) && $changed(fclk_q))
      |-> (slot_q == '0 || slot_q == SLOT_W'(SAMPLE_W)));
endmodule

// File: rtl/stereo_ser_port.sv
module stereo_ser_port #(
  parameter int SAMPLE_W = 16,
  parameter int DIV_W    = 8,
  parameter int SYNC_N   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                ext_dac_i,
  input  logic                master_i,
  input  logic [1:0]          fmt_i,
  input  logic                offset_bin_i,
  input  logic [DIV_W-1:0]    clk_div_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                bclk_i,
  input  logic                fclk_i,
  output logic                bclk_o,
  output logic                fclk_o,
  output logic                sdata_o
);
  logic                run;
  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;
  logic                m_bclk, m_fall, s_fall, step;
  logic [1:0]          s_sync;

  assign run = en_i & ext_dac_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (valid_i) begin
      hold_l_q <= left_i;
      hold_r_q <= right_i;
    end
  end

  ser_bclk_gen #(.DIV_W(DIV_W)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run & master_i),
    .div_i  (clk_div_i),
    .bclk_o (m_bclk),
    .fall_o (m_fall)
  );

  ser_sync #(.STAGES(SYNC_N), .N(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({fclk_i, bclk_i}),
    .sync_o  (s_sync),
    .fall0_o (s_fall)
  );

  assign step = master_i ? m_fall : (run & s_fall);

  ser_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .step_i       (step),
    .master_i     (master_i),
    .ext_fclk_i   (s_sync[1]),
    .fmt_i        (fmt_i),
    .offset_bin_i (offset_bin_i),
    .hold_l_i     (hold_l_q),
    .hold_r_i     (hold_r_q),
    .sdata_o      (sdata_o),
    .fclk_o       (fclk_o)
  );

  assign bclk_o = master_i & m_bclk;

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (sdata_o == 1'b0 && fclk_o == 1'b0 && bclk_o == 1'b0));

  assert_data_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && master_i && $past(master_i) && $changed(sdata_o)) |-> $fell(bclk_o));
endmodule

// File: tb/sim_stereo_ser_port.sv
`timescale 1ns/1ps
module sim_stereo_ser_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, ext_dac_i = 1'b1, master_i = 1'b1;
  logic [1:0]  fmt_i = 2'b00;
  logic        offset_bin_i = 1'b0;
  logic [7:0]  clk_div_i = 8'd1;
  logic        valid_i = 1'b0;
  logic [15:0] left_i = '0, right_i = '0;
  logic        bclk_i = 1'b1, fclk_i = 1'b0;
  logic        bclk_o, fclk_o, sdata_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stereo_ser_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .ext_dac_i(ext_dac_i),
    .master_i(master_i), .fmt_i(fmt_i), .offset_bin_i(offset_bin_i),
    .clk_div_i(clk_div_i), .valid_i(valid_i), .left_i(left_i), .right_i(right_i),
    .bclk_i(bclk_i), .fclk_i(fclk_i), .bclk_o(bclk_o), .fclk_o(fclk_o), .sdata_o(sdata_o)
  );

  // {fmt, offset, left, right}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {2'b00, 1'b0, 16'hA5C3, 16'h1234},
    {2'b01, 1'b0, 16'h8001, 16'h7FFE},
    {2'b10, 1'b0, 16'h0F0F, 16'hF0F0},
    {2'b11, 1'b0, 16'h8000, 16'h0001},
    {2'b00, 1'b1, 16'h0000, 16'hFFFF},
    {2'b11, 1'b1, 16'h7FFF, 16'h4321},
    {2'b01, 1'b1, 16'h1357, 16'h9BDF},
    {2'b00, 1'b0, 16'hFFFF, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_pair(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    left_i = l; right_i = r; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic rise(output logic fc, output logic sd);
    do @(negedge clk); while (bclk_o !== 1'b0);
    do @(negedge clk); while (bclk_o !== 1'b1);
    fc = fclk_o; sd = sdata_o;
  endtask

  // bits[0] is the slot where the word begins
  task automatic decode(input logic [32:0] b, input logic lsb,
                        output logic [15:0] l, output logic [15:0] r);
    for (int j = 0; j < 16; j++) begin
      if (lsb) begin l[j] = b[j]; r[j] = b[16+j]; end
      else begin l[15-j] = b[j]; r[15-j] = b[16+j]; end
    end
  endtask

  task automatic cap_m(input logic i2s, input logic lsb,
                       output logic [15:0] l, output logic [15:0] r);
    logic [32:0] bits;
    logic pl, li, fc, sd;
    pl = 1'b1;
    bits = '0;
    for (int n = 0; n < 100; n++) begin
      rise(fc, sd);
      li = fc ^ i2s;
      if (li && !pl) break;
      pl = li;
    end
    bits[0] = sd;
    for (int j = 1; j < 33; j++) begin
      rise(fc, sd);
      bits[j] = sd;
    end
    decode(i2s ? (bits >> 1) : bits, lsb, l, r);
  endtask

  task automatic restart(input logic [1:0] f, input logic off, input logic mst);
    @(negedge clk); en_i = 1'b0;
    repeat (3) @(negedge clk);
    fmt_i = f; offset_bin_i = off; master_i = mst;
  endtask

  task automatic slave_run(input logic i2s, input logic lsb, input string req);
    logic [95:0] sb;
    logic [15:0] l, r;
    logic        seen;
    seen = 1'b0;
    bclk_i = 1'b1; fclk_i = i2s;
    @(negedge clk); en_i = 1'b1;
    for (int f = 0; f < 3; f++) begin
      for (int s = 0; s < 32; s++) begin
        @(negedge clk);
        bclk_i = 1'b0; fclk_i = (s < 16) ^ i2s;
        repeat (8) begin
          @(negedge clk);
          if (bclk_o !== 1'b0 || fclk_o !== 1'b0) seen = 1'b1;
        end
        bclk_i = 1'b1;
        sb[f*32+s] = sdata_o;
        repeat (8) @(negedge clk);
      end
    end
    decode(sb[32 + int'(i2s) +: 33], lsb, l, r);
    chk({req, " R9 slave left"}, {16'h0, l}, 32'h0000C0DE);
    chk({req, " R9 slave right"}, {16'h0, r}, 32'h0000BEEF);
    chk("R9 clocks held low in slave", {31'h0, seen}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] l, r, el, er;
    logic [1:0]  f;
    logic        off, fc, sd, seen;
    int          per;

    en_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset bclk", {31'h0, bclk_o}, 32'h0);
    chk("R1 reset fclk", {31'h0, fclk_o}, 32'h0);
    chk("R1 reset sdata", {31'h0, sdata_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {29'h0, bclk_o, fclk_o, sdata_o}, 32'h0);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      f = VEC[v][34:33]; off = VEC[v][32];
      restart(f, off, 1'b1);
      write_pair(VEC[v][31:16], VEC[v][15:0]);
      @(negedge clk); en_i = 1'b1;
      cap_m(f == 2'b11, f == 2'b01, l, r);
      el = VEC[v][31:16] ^ (off ? 16'h8000 : 16'h0);
      er = VEC[v][15:0]  ^ (off ? 16'h8000 : 16'h0);
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d left", v), {16'h0, l}, {16'h0, el});
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d right", v), {16'h0, r}, {16'h0, er});
    end

    // R7: repeat without new pair, then mid-run update
    cap_m(1'b0, 1'b0, l, r);
    chk("R7 repeat left", {16'h0, l}, 32'h0000FFFF);
    chk("R7 repeat right", {16'h0, r}, 32'h00000000);
    write_pair(16'h2468, 16'hACE1);
    cap_m(1'b0, 1'b0, l, r);
    chk("R7 new pair left", {16'h0, l}, 32'h00002468);
    chk("R7 new pair right", {16'h0, r}, 32'h0000ACE1);

    // R8: bit clock period with divider 3
    restart(2'b00, 1'b0, 1'b1);
    clk_div_i = 8'd3;
    @(negedge clk); en_i = 1'b1;
    rise(fc, sd);
    per = 0;
    do begin @(negedge clk); per++; end while (bclk_o !== 1'b0);
    do begin @(negedge clk); per++; end while (bclk_o !== 1'b1);
    chk("R8 bclk period div3", per, 32'd8);
    clk_div_i = 8'd1;

    // R10: ext option off, then enable off
    restart(2'b00, 1'b0, 1'b1);
    ext_dac_i = 1'b0; en_i = 1'b1;
    seen = 1'b0;
    repeat (200) begin
      @(negedge clk);
      if (bclk_o !== 1'b0 || fclk_o !== 1'b0 || sdata_o !== 1'b0) seen = 1'b1;
    end
    chk("R10 quiet with ext option off", {31'h0, seen}, 32'h0);
    ext_dac_i = 1'b1; en_i = 1'b0;
    seen = 1'b0;
    repeat (200) begin
      @(negedge clk);
      if (bclk_o !== 1'b0 || fclk_o !== 1'b0 || sdata_o !== 1'b0) seen = 1'b1;
    end
    chk("R10 quiet with enable off", {31'h0, seen}, 32'h0);

    // R9: slave, left-justified MSB first and I2S-style
    write_pair(16'hC0DE, 16'hBEEF);
    restart(2'b00, 1'b0, 1'b0);
    slave_run(1'b0, 1'b0, "fmt00");
    restart(2'b11, 1'b0, 1'b0);
    slave_run(1'b1, 1'b0, "fmt11");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule